// File: doc/BRIEF.md
# Up-Counting Timer with Trigger-Driven Slave Control

This block is an up-counter with a programmable wrap value. A slave controller can tie the counter to an external trigger pin. The pin is brought into the clock domain by a two-stage synchronizer. A polarity stage then picks which level, and so which edge, counts as active. Configuration arrives as static input fields, as a memory-mapped register block would present them. Software clears the sticky trigger flag with a one-cycle `flag_clr` strobe.

The slave controller is a small state machine with four states:
- `ST_FREE`: slave control off. The counter steps on every enabled cycle.
- `ST_RESET`: reset mode. An active edge clears the counter and raises the flag.
- `ST_GATE_HOLD`: gated mode while the counter is stopped.
- `ST_GATE_RUN`: gated mode while the counter is running.

The controller enters one of these states on every cycle, chosen by the mode field. In gated mode it takes `ST_GATE_RUN` when the enable and the active trigger level are both true, and `ST_GATE_HOLD` otherwise. A move from `ST_GATE_HOLD` to `ST_GATE_RUN` is a start event. The reverse move is a stop event. Entering gated mode from `ST_FREE` or `ST_RESET` counts as coming from a stopped counter.

Top module: `tmr_slave_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `count`, `trig_flag` and `trig_irq` are 0.
- R2: With `slave_mode` at 3'b000 or any code other than 3'b100 and 3'b101, the counter advances by one per clock while `cnt_en`=1, holds while `cnt_en`=0, and ignores the trigger pin completely; no flag is set.
- R3: A counter step taken when `count` is greater than or equal to `reload` yields 0 instead of `count`+1.
- R4: With `slave_mode`=3'b100, an active trigger edge clears the counter to 0, even when `cnt_en`=0, and counting then resumes from 0. Latency: if the pin changes between two clock edges, `count` reads 0 after the third following clock edge. A level held after the edge causes no further clears.
- R5: In that mode each such clearing edge sets `trig_flag`, visible in the same cycle as the cleared count.
- R6: With `slave_mode`=3'b101, the counter steps only while `cnt_en`=1 and the trigger is at its active level, and holds otherwise. The first step after the pin turns active lands on the third clock edge. The last step lands on the second edge after the pin turns inactive.
- R7: In gated mode, `trig_flag` is set whenever counting starts and whenever it stops. This includes a start or stop caused by `cnt_en`.
- R8: The polarity pair {`pol`,`pol_n`} = 2'b10 makes the low level and the falling edge active. Every other pair makes the high level and the rising edge active.
- R9: Only `trig_sel`=3'b101 routes the pin to the controller. With any other value the trigger is held inactive: there are no clears in reset mode and no counting in gated mode.
- R10: `trig_flag` stays set until a `flag_clr` strobe clears it at the next clock edge. A trigger event in the same cycle as the strobe wins, and the flag stays 1.
- R11: `trig_irq` equals `trig_flag` AND `irq_en` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Raw external trigger pin |
| cnt_en | input | 1 | Counter enable |
| reload | input | CNT_W | Wrap value |
| slave_mode | input | 3 | 000 off, 100 reset mode, 101 gated mode |
| trig_sel | input | 3 | Trigger source select, 101 = pin |
| pol | input | 1 | Polarity bit |
| pol_n | input | 1 | Complementary polarity bit |
| irq_en | input | 1 | Trigger interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| count | output | CNT_W | Counter value |
| trig_flag | output | 1 | Sticky trigger flag |
| trig_irq | output | 1 | Trigger interrupt request |

## Verification
A corrupted synchronizer or edge register shows up as a clear or a gate change landing one cycle early or late. It is caught within three clock cycles of a pin change by a `count` or `trig_flag` mismatch. A controller state that disagrees with the real gate condition produces a missing or spurious start or stop flag on the next cycle in gated mode, and a counter that runs or stalls against the expected value. Counter faults show at the next step as a wrong value after the reload wrap.

// File: rtl/tmr_slv_pkg.sv
package tmr_slv_pkg;

    localparam logic [2:0] SMODE_OFF   = 3'b000;
    localparam logic [2:0] SMODE_RESET = 3'b100;
    localparam logic [2:0] SMODE_GATED = 3'b101;
    localparam logic [2:0] TSRC_PIN    = 3'b101;

    typedef enum logic [1:0] {
        ST_FREE      = 2'd0,
        ST_RESET     = 2'd1,
        ST_GATE_HOLD = 2'd2,
        ST_GATE_RUN  = 2'd3
    } slv_state_t;

endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic src_ok,
    input  logic invert,
    output logic act_lvl,
    output logic act_rise
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= trig_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], trig_in};
            end
        end
    endgenerate

    assign act_lvl = src_ok & (chain_q[TOP] ^ invert);

    // prev resets to 1 so that the first active level seen after reset is not taken as an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= act_lvl;
    end

    assign act_rise = act_lvl & ~prev_q;
endmodule

// File: rtl/tmr_slave_fsm.sv
module tmr_slave_fsm
    import tmr_slv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] slave_mode,
    input  logic       cnt_en,
    input  logic       act_lvl,
    input  logic       act_rise,
    output logic       cnt_clear,
    output logic       cnt_step,
    output logic       trig_evt
);
    slv_state_t state_q, state_d;
    logic       run;

    assign run = cnt_en & act_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (slave_mode)
            SMODE_RESET: state_d = ST_RESET;
            SMODE_GATED: state_d = run ? ST_GATE_RUN : ST_GATE_HOLD;
            default:     state_d = ST_FREE;
        endcase
    end

    always_comb begin
        cnt_clear = 1'b0;
        cnt_step  = 1'b0;
        trig_evt  = 1'b0;
        if (slave_mode == SMODE_GATED) begin
            cnt_step = run;
            unique case (state_q)
                ST_GATE_RUN: trig_evt = ~run;
                ST_FREE, ST_RESET, ST_GATE_HOLD: trig_evt = run;
            endcase
        end else if (slave_mode == SMODE_RESET) begin
            cnt_clear = act_rise;
            trig_evt  = act_rise;
            cnt_step  = cnt_en;
        end else begin
            cnt_step  = cnt_en;
        end
    end
endmodule

// File: rtl/tmr_upcount.sv
module tmr_upcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear)            cnt_q <= '0;
        else if (step) begin
            if (cnt_q >= reload)   cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/tmr_slave_timer.sv
module tmr_slave_timer
    import tmr_slv_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] reload,
    input  logic [2:0]       slave_mode,
    input  logic [2:0]       trig_sel,
    input  logic             pol,
    input  logic             pol_n,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             trig_flag,
    output logic             trig_irq
);
    logic act_lvl, act_rise, cnt_clear, cnt_step, trig_evt, flag_q;

    tmr_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .src_ok(trig_sel == TSRC_PIN), .invert(pol & ~pol_n),
        .act_lvl(act_lvl), .act_rise(act_rise)
    );

    tmr_slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .cnt_en(cnt_en),
        .act_lvl(act_lvl), .act_rise(act_rise),
        .cnt_clear(cnt_clear), .cnt_step(cnt_step), .trig_evt(trig_evt)
    );

    tmr_upcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .step(cnt_step),
        .reload(reload), .count(count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (trig_evt) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign trig_flag = flag_q;
    assign trig_irq  = flag_q & irq_en;
endmodule

// File: rtl/tmr_slave_timer_chk.sv
module tmr_slave_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [CNT_W-1:0] reload,
    input logic [2:0]       slave_mode,
    input logic [2:0]       trig_sel,
    input logic             irq_en,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             trig_flag,
    input logic             trig_irq
);
    a_r2_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode == 3'b000 && cnt_en && count < reload) |=> count == CNT_W'($past(count) + 1'b1));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode == 3'b000 && cnt_en && count >= reload) |=> count == '0);

    a_r2_free_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode == 3'b000 && !cnt_en) |=> $stable(count));

    a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode == 3'b101 && !cnt_en) |=> $stable(count));

    a_r9_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode == 3'b101 && trig_sel != 3'b101) |=> $stable(count));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !flag_clr) |=> trig_flag);

    a_r11_irq: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq == (trig_flag && irq_en));
endmodule

bind tmr_slave_timer tmr_slave_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reload(reload),
    .slave_mode(slave_mode), .trig_sel(trig_sel), .irq_en(irq_en),
    .flag_clr(flag_clr), .count(count), .trig_flag(trig_flag), .trig_irq(trig_irq)
);

// File: tb/test_tmr_slave_timer.sv
`timescale 1ns/1ps
module test_tmr_slave_timer;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_in = 1'b0, cnt_en = 1'b0, pol = 1'b0, pol_n = 1'b0;
    logic             irq_en = 1'b0, flag_clr = 1'b0;
    logic [CNT_W-1:0] reload = 16'd10;
    logic [2:0]       slave_mode = 3'b000, trig_sel = 3'b101;
    logic [CNT_W-1:0] count;
    logic             trig_flag, trig_irq;

    int checks = 0;
    int failures = 0;
    logic [CNT_W-1:0] c0;

    always #4 clk = ~clk;

    tmr_slave_timer #(.CNT_W(CNT_W)) i_tmr_slave_timer (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cnt_en(cnt_en), .reload(reload),
        .slave_mode(slave_mode), .trig_sel(trig_sel), .pol(pol), .pol_n(pol_n),
        .irq_en(irq_en), .flag_clr(flag_clr), .count(count),
        .trig_flag(trig_flag), .trig_irq(trig_irq)
    );

    // reference model built from the requirements
    logic m_s1, m_s2, m_aprev, m_gprev, m_flag;
    logic [CNT_W-1:0] m_cnt;

    function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] c, logic [CNT_W-1:0] rl);
        return (c >= rl) ? '0 : c + 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic act, rise, run, clr, stp, evt;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_aprev = 1; m_gprev = 0; m_flag = 0; m_cnt = '0;
        end else begin
            act  = (trig_sel == 3'b101) & (m_s2 ^ (pol & ~pol_n));
            rise = act & ~m_aprev;
            run  = cnt_en & act;
            clr = 0; stp = 0; evt = 0;
            case (slave_mode)
                3'b100:  begin clr = rise; evt = rise; stp = cnt_en; end
                3'b101:  begin stp = run; evt = (run != m_gprev); end
                default: stp = cnt_en;
            endcase
            m_gprev = (slave_mode == 3'b101) ? run : 1'b0;
            m_aprev = act;
            m_s2 = m_s1;
            m_s1 = trig_in;
            if (clr)      m_cnt = '0;
            else if (stp) m_cnt = next_count(m_cnt, reload);
            if (evt)           m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        tick(3);
        check("R1 count in reset", count, 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 count", count, 0);
        check("R1 flag", trig_flag, 0);
        check("R1 irq", trig_irq, 0);

        // R2 free run
        cnt_en = 1; tick(5);
        check("R2 free count", count, 5);
        trig_in = 1; tick(4);
        check("R2 trigger ignored", count, 9);
        cnt_en = 0; tick(3);
        check("R2 hold", count, 9);
        cnt_en = 1; tick(1);
        check("R3 reach reload", count, 10);
        tick(1);
        check("R3 wrap", count, 0);
        check("R2 no flag in free mode", trig_flag, 0);

        // R4 R5 reset mode, rising
        trig_in = 0; reload = 16'd100; tick(3);
        slave_mode = 3'b100; tick(4);
        c0 = count;
        trig_in = 1; tick(2);
        check("R4 before sync", count, c0 + 2);
        tick(1);
        check("R4 cleared", count, 0);
        check("R5 flag", trig_flag, 1);
        check("R11 irq off", trig_irq, 0);
        irq_en = 1; #1;
        check("R11 irq on", trig_irq, 1);
        tick(2);
        check("R4 resume", count, 2);
        tick(5);
        check("R4 level no reclear", count, 7);
        flag_clr = 1; tick(1); flag_clr = 0;
        check("R10 cleared", trig_flag, 0);
        check("R11 irq follows", trig_irq, 0);

        // R8 falling polarity
        slave_mode = 3'b000; pol = 1; pol_n = 0; tick(3);
        slave_mode = 3'b100; tick(2);
        trig_in = 0; tick(3);
        check("R8 falling clears", count, 0);
        check("R8 flag", trig_flag, 1);
        flag_clr = 1; tick(1); flag_clr = 0;

        // R9 other source
        trig_sel = 3'b000; tick(3);
        c0 = count;
        trig_in = 1; tick(3); trig_in = 0; tick(3);
        check("R9 no clear", count, c0 + 6);
        check("R9 no flag", trig_flag, 0);
        slave_mode = 3'b000; trig_sel = 3'b101; pol = 0; tick(3);

        // R6 R7 gated
        slave_mode = 3'b101; tick(1);
        c0 = count; tick(3);
        check("R6 inactive hold", count, c0);
        trig_in = 1; tick(2);
        check("R6 sync latency", count, c0);
        check("R7 not yet", trig_flag, 0);
        tick(1);
        check("R6 first step", count, c0 + 1);
        check("R7 start flag", trig_flag, 1);
        tick(4);
        check("R6 running", count, c0 + 5);
        flag_clr = 1; tick(1); flag_clr = 0;
        check("R10 clear in gated", trig_flag, 0);
        trig_in = 0; tick(2);
        check("R6 last steps", count, c0 + 8);
        tick(1);
        check("R6 stopped", count, c0 + 8);
        check("R7 stop flag", trig_flag, 1);
        flag_clr = 1; tick(1); flag_clr = 0;
        trig_in = 1; cnt_en = 0; tick(5);
        check("R6 enable low", count, c0 + 8);
        check("R7 no start while disabled", trig_flag, 0);
        cnt_en = 1; tick(1);
        check("R6 enable start", count, c0 + 9);
        check("R7 enable start flag", trig_flag, 1);

        // R10 event wins over clear
        slave_mode = 3'b100; trig_in = 0; tick(3);
        flag_clr = 1; tick(1); flag_clr = 0;
        trig_in = 1; tick(2);
        flag_clr = 1; tick(1); flag_clr = 0;
        check("R10 event wins", trig_flag, 1);
        check("R4 clear with strobe", count, 0);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            string tag;
            tag = (slave_mode == 3'b100) ? "R4" : (slave_mode == 3'b101) ? "R6" : "R2";
            check({tag, " random count"}, count, m_cnt);
            check("R10 random flag", trig_flag, m_flag);
            check("R11 random irq", trig_irq, m_flag & irq_en);
            if (i % 60 == 0) begin
                int m;
                m = $urandom_range(0, 3);
                slave_mode = (m == 0) ? 3'b000 : (m == 1) ? 3'b100 : (m == 2) ? 3'b101 : 3'b010;
                trig_sel = ($urandom_range(0, 5) == 0) ? 3'b011 : 3'b101;
                pol   = 1'($urandom_range(0, 1));
                pol_n = ($urandom_range(0, 3) == 0);
                reload = 16'($urandom_range(0, 20));
                irq_en = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 7) == 0) trig_in = ~trig_in;
            cnt_en   = ($urandom_range(0, 15) != 0);
            flag_clr = ($urandom_range(0, 15) == 0);
            tick(1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule